// File: doc/BRIEF.md
# Programmable Analog Scan Sequencer

This block runs a small scan program that selects, one after another, the analog channels a converter should sample. The program lives in a local sequence memory as pairs of 16-bit words. Each pair names a board, a port on that board and a port group, and says whether the channel is sampled or only selected. For every pair the sequencer drives a channel select and then waits a programmable pacing interval. If the pair asks for a sample, the sequencer issues a conversion strobe at the end of that interval. The converted value arrives on a data input and is pushed into an input FIFO, which software drains one word per read.

A scan can be launched in three ways: by an internal one-shot start bit, by an external trigger pulse, or by the rising edge of an external start level. A sample counter gathers a programmed number of samples into a block, even when the block spans several scans. It then raises a one-cycle block-complete request. The same request is forced when the external start level falls while a partial block is pending, so that a short acquisition is not left stranded. A soft reset command returns the sequencer, the FIFO, the sample counter and all enables to their idle state.

Top module: `scan_seq_top`

## Requirements
- R1: A program entry is two words at addresses 2k and 2k+1. The channel select `mux_sel` takes the value {group, port, board}, with these sources:
  - group is first-word bits 1:0 and lands in `mux_sel` 7:6;
  - port is second-word bits 5:3 and lands in `mux_sel` 5:3;
  - board is second-word bits 2:0 and lands in `mux_sel` 2:0.
- R2: A pair whose two words are both 0x0000 ends the scan. The next start always begins again at entry 0.
- R3: The pacing counter loads the rate value and counts up by one per clock. It strobes when it passes 0xFFFF, so each entry's interval lasts 65536 − rate cycles. Consecutive entries are spaced 3 + (65536 − rate) cycles apart.
- R4: Second-word bits 7:6 = 11 (hold) make the entry produce exactly one `sample_stb`. Bits 7:6 = 01 (track) select the channel but produce no strobe.
- R5: The control bits that start a scan are:
  - bit 4 is a one-shot internal start that clears itself once a scan runs;
  - with bit 6 set, a high `ext_trig` starts a scan;
  - with bit 5 set, a rising edge of `ext_start` starts a scan.
- R6: Each strobe pushes the `adc_data` value present in that cycle into the FIFO. `fifo_dout` shows the oldest word, and each `fifo_pop` removes one word. Status bit 1 is 1 exactly while the FIFO holds data. A pop on an empty FIFO has no effect.
- R7: Status bits 13:6 show the current channel select. All other status bits except bit 1 read 0.
- R8: A start request from any source that arrives while a scan is running is discarded. It causes neither a second scan nor a restart.
- R9: `blk_done` pulses for one cycle, one cycle after the strobe that brings the sample count to the programmed block size. The count then restarts at zero and carries across scans.
- R10: With bit 5 set, a falling edge of `ext_start` while the sample count is non-zero forces a `blk_done` pulse and clears the count.
- R11: A control write with bit 0 set (soft reset) takes effect at the next clock. It returns the sequencer to idle at entry 0, empties the FIFO, clears the sample count and clears bits 7:4.
- R12: `fifo_irq` is high exactly when control bit 7 is set and the FIFO is not empty.
- R13: After `rst`, `mux_sel`, `status`, `sample_stb`, `blk_done` and `fifo_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control value: bit0 soft reset, bit4 internal start, bit5 external start enable, bit6 external trigger enable, bit7 FIFO interrupt enable |
| rate_we | input | 1 | Pacing rate write strobe |
| rate_wdata | input | 16 | Pacing rate value (reset value 0xFFEC) |
| blk_we | input | 1 | Block size write strobe |
| blk_wdata | input | 16 | Samples per block |
| seq_we | input | 1 | Sequence memory write strobe |
| seq_waddr | input | 11 | Sequence memory word address |
| seq_wdata | input | 16 | Sequence memory word |
| ext_start | input | 1 | External start level |
| ext_trig | input | 1 | External trigger |
| adc_data | input | 16 | Converted sample value |
| fifo_pop | input | 1 | Remove the oldest FIFO word |
| mux_sel | output | 8 | Current channel select {group, port, board} |
| sample_stb | output | 1 | Conversion strobe |
| status | output | 16 | Bit 1 FIFO not empty, bits 13:6 current channel |
| fifo_dout | output | 16 | Oldest FIFO word |
| fifo_irq | output | 1 | FIFO interrupt request |
| blk_done | output | 1 | Block-complete request pulse |

## Verification
The scan program mixes hold and track entries. It uses every group value and extreme board and port numbers, and includes an entry that is all zero except for its leading code, which must not be read as a restart. Together these separate field placement errors, strobes issued for track entries, and false restarts.

The entry-to-entry spacing is measured with a track entry in the gap, which exposes pacing and fetch-overhead errors. The same program is launched by each of the three start sources, with a second request injected mid-scan to catch restarts.

The block size is chosen so that complete blocks straddle scan boundaries, and the final partial block is then flushed by a falling start level. The FIFO contents are compared against the data captured at each strobe, before and after a soft reset.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    localparam int WORD_W = 16;

    // control register bit positions
    localparam int CTL_SRST   = 0;
    localparam int CTL_ISTART = 4;
    localparam int CTL_XSTART = 5;
    localparam int CTL_TRIG   = 6;
    localparam int CTL_IEN    = 7;

    // second-word action codes in bits 7:6
    localparam logic [1:0] ACT_HOLD  = 2'b11;
    localparam logic [1:0] ACT_TRACK = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_LO,
        ST_FETCH_HI,
        ST_DECODE,
        ST_PACE
    } seq_state_e;

    typedef struct packed {
        logic [1:0] group;
        logic [2:0] port;
        logic [2:0] board;
    } chan_sel_t;

    typedef struct packed {
        logic      restart;
        logic      hold;
        chan_sel_t sel;
    } entry_t;

    typedef struct packed {
        logic irq_en;
        logic trig_en;
        logic xstart_en;
        logic int_start;
    } ctl_t;

    function automatic entry_t decode_entry(input logic [WORD_W-1:0] lo,
                                            input logic [WORD_W-1:0] hi);
        entry_t e;
        e.restart   = (lo == '0) && (hi == '0);
        e.hold      = (hi[7:6] == ACT_HOLD);
        e.sel.group = lo[1:0];
        e.sel.port  = hi[5:3];
        e.sel.board = hi[2:0];
        return e;
    endfunction

endpackage

// File: rtl/seq_ram.sv
module seq_ram #(
    parameter int WORDS = 2048,
    parameter int DW    = 16,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/pace_timer.sv
module pace_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         run,
    input  logic [W-1:0] rate,
    output logic         ovf
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= rate;
        else if (run)  cnt <= cnt + 1'b1;
    end

    assign ovf = run && (cnt == '1);

    // R3
    pace_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !load && !ovf) |=> (cnt != '0));

    // R3
    pace_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf && !load) |=> (cnt == '0));

endmodule

// File: rtl/scan_fifo.sv
module scan_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          nempty
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count;
    logic          full, do_push, do_pop;

    assign full    = (count == (AW+1)'(DEPTH));
    assign nempty  = (count != '0);
    assign do_push = push && !full;
    assign do_pop  = pop && nempty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R6
    pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !nempty && !push && !clr) |=> !nempty);

    // R11
    clr_empty_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !nempty);

    // R6
    push_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !clr) |=> nempty);

endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top
    import scan_seq_pkg::*;
#(
    parameter int          RAM_WORDS    = 2048,
    parameter int          FIFO_DEPTH   = 16,
    parameter int          CNT_W        = 16,
    parameter int          BLK_DEFAULT  = 64,
    parameter logic [15:0] RATE_DEFAULT = 16'hFFEC,
    localparam int         SEQ_AW       = $clog2(RAM_WORDS),
    localparam int         PTR_W        = SEQ_AW - 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ctl_we,
    input  logic [7:0]         ctl_wdata,
    input  logic               rate_we,
    input  logic [WORD_W-1:0]  rate_wdata,
    input  logic               blk_we,
    input  logic [CNT_W-1:0]   blk_wdata,
    input  logic               seq_we,
    input  logic [SEQ_AW-1:0]  seq_waddr,
    input  logic [WORD_W-1:0]  seq_wdata,
    input  logic               ext_start,
    input  logic               ext_trig,
    input  logic [WORD_W-1:0]  adc_data,
    input  logic               fifo_pop,
    output logic [7:0]         mux_sel,
    output logic               sample_stb,
    output logic [15:0]        status,
    output logic [WORD_W-1:0]  fifo_dout,
    output logic               fifo_irq,
    output logic               blk_done
);

    seq_state_e          state;
    logic [PTR_W-1:0]    ptr;
    logic [WORD_W-1:0]   w0_q, ram_rdata;
    logic [SEQ_AW-1:0]   ram_raddr;
    chan_sel_t           chan_q;
    logic                hold_q;
    ctl_t                ctl_q;
    logic [WORD_W-1:0]   rate_q;
    logic [CNT_W-1:0]    blk_q, smp_cnt;
    logic                xstart_q, done_q;
    logic                srst, start_req, xrise, xfall;
    logic                pace_load, pace_run, pace_ovf;
    logic                fifo_nempty;
    logic                ctl_unused;
    entry_t              ent;

    assign ctl_unused = ^ctl_wdata[3:1];

    // ---------------- sequence memory ----------------
    assign ram_raddr = {ptr, (state == ST_FETCH_HI)};

    seq_ram #(.WORDS(RAM_WORDS), .DW(WORD_W)) u_ram (
        .clk   (clk),
        .we    (seq_we),
        .waddr (seq_waddr),
        .wdata (seq_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    assign ent = decode_entry(w0_q, ram_rdata);

    // ---------------- control ----------------
    assign srst  = ctl_we && ctl_wdata[CTL_SRST];
    assign xrise = ctl_q.xstart_en && !xstart_q && ext_start;
    assign xfall = ctl_q.xstart_en && xstart_q && !ext_start;
    assign start_req = ctl_q.int_start || (ctl_q.trig_en && ext_trig) || xrise;

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            ctl_q <= '0;
        end else if (ctl_we) begin
            ctl_q.irq_en    <= ctl_wdata[CTL_IEN];
            ctl_q.trig_en   <= ctl_wdata[CTL_TRIG];
            ctl_q.xstart_en <= ctl_wdata[CTL_XSTART];
            ctl_q.int_start <= ctl_wdata[CTL_ISTART];
        end else if (state != ST_IDLE) begin
            ctl_q.int_start <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= RATE_DEFAULT;
            blk_q  <= CNT_W'(BLK_DEFAULT);
        end else begin
            if (rate_we) rate_q <= rate_wdata;
            if (blk_we)  blk_q  <= blk_wdata;
        end
    end

    // ---------------- sequencer ----------------
    always_ff @(posedge clk) begin
        if (rst || srst) begin
            state  <= ST_IDLE;
            ptr    <= '0;
            w0_q   <= '0;
            chan_q <= '0;
            hold_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_req) begin
                        ptr   <= '0;
                        state <= ST_FETCH_LO;
                    end
                end
                ST_FETCH_LO: state <= ST_FETCH_HI;
                ST_FETCH_HI: begin
                    w0_q  <= ram_rdata;
                    state <= ST_DECODE;
                end
                ST_DECODE: begin
                    if (ent.restart) begin
                        ptr   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        chan_q <= ent.sel;
                        hold_q <= ent.hold;
                        state  <= ST_PACE;
                    end
                end
                ST_PACE: begin
                    if (pace_ovf) begin
                        ptr   <= ptr + 1'b1;
                        state <= ST_FETCH_LO;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign pace_load = (state == ST_DECODE) && !ent.restart;
    assign pace_run  = (state == ST_PACE);

    pace_timer #(.W(WORD_W)) u_pace (
        .clk  (clk),
        .rst  (rst),
        .load (pace_load),
        .run  (pace_run),
        .rate (rate_q),
        .ovf  (pace_ovf)
    );

    assign sample_stb = pace_ovf && hold_q;
    assign mux_sel    = chan_q;

    // ---------------- sample FIFO ----------------
    scan_fifo #(.DEPTH(FIFO_DEPTH), .DW(WORD_W)) u_fifo (
        .clk    (clk),
        .rst    (rst),
        .clr    (srst),
        .push   (sample_stb),
        .din    (adc_data),
        .pop    (fifo_pop),
        .dout   (fifo_dout),
        .nempty (fifo_nempty)
    );

    // ---------------- block counter ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            smp_cnt  <= '0;
            done_q   <= 1'b0;
            xstart_q <= 1'b0;
        end else begin
            xstart_q <= ext_start;
            done_q   <= 1'b0;
            if (srst) begin
                smp_cnt <= '0;
            end else if (xfall && (smp_cnt != '0)) begin
                smp_cnt <= '0;
                done_q  <= 1'b1;
            end else if (sample_stb) begin
                if (smp_cnt + CNT_W'(1) == blk_q) begin
                    smp_cnt <= '0;
                    done_q  <= 1'b1;
                end else begin
                    smp_cnt <= smp_cnt + CNT_W'(1);
                end
            end
        end
    end

    assign blk_done = done_q;
    assign fifo_irq = ctl_q.irq_en && fifo_nempty;
    assign status   = {2'b00, chan_q, 4'b0000, fifo_nempty, 1'b0};

    // ---------------- assertions ----------------
    // R2
    restart_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECODE && ent.restart && !srst) |=> (state == ST_IDLE && ptr == '0));

    // R1
    chan_load_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECODE && !ent.restart && !srst) |=>
        (mux_sel == {$past(w0_q[1:0]), $past(ram_rdata[5:0])}));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PACE && !pace_ovf && !srst) |=> (state == ST_PACE && $stable(ptr)));

    // R9
    blk_clear_chk: assert property (@(posedge clk) disable iff (rst)
        blk_done |-> (smp_cnt == '0));

    // R11
    soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
        srst |=> (state == ST_IDLE && ptr == '0 && ctl_q == '0 && smp_cnt == '0));

    // R4
    track_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECODE && !ent.restart && ram_rdata[7:6] == ACT_TRACK && !srst)
        |=> !hold_q);

endmodule

// File: tb/sim_scan_seq_top.sv
module sim_scan_seq_top;

    typedef struct packed {
        logic [15:0] w0;
        logic [15:0] w1;
        logic [7:0]  sel;
        logic        stb;
    } vec_t;

    localparam int   NENT = 5;
    localparam vec_t PROG [NENT] = '{
        '{16'h0081, 16'h00DA, 8'h5A, 1'b1},
        '{16'h0080, 16'h006F, 8'h2F, 1'b0},
        '{16'h0083, 16'h00F8, 8'hF8, 1'b1},
        '{16'h0082, 16'h00C5, 8'h85, 1'b1},
        '{16'h0080, 16'h00C0, 8'h00, 1'b1}
    };
    localparam logic [15:0] RATE = 16'hFFFC;
    localparam int PACE = 65536 - int'(RATE);
    localparam int STEP = 3 + PACE;

    logic        clk = 1'b0;
    logic        rst;
    logic        ctl_we, rate_we, blk_we, seq_we;
    logic [7:0]  ctl_wdata;
    logic [15:0] rate_wdata, blk_wdata, seq_wdata, adc_data;
    logic [10:0] seq_waddr;
    logic        ext_start, ext_trig, fifo_pop;
    logic [7:0]  mux_sel;
    logic        sample_stb, fifo_irq, blk_done;
    logic [15:0] status, fifo_dout;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int n      = 0;
    int nd     = 0;
    logic [7:0]  stb_sel  [64];
    logic [15:0] stb_stat [64];
    logic [15:0] stb_data [64];
    int          stb_t    [64];
    int          done_at  [16];

    always #10 clk = ~clk;

    scan_seq_top u0 (
        .clk(clk), .rst(rst),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .rate_we(rate_we), .rate_wdata(rate_wdata),
        .blk_we(blk_we), .blk_wdata(blk_wdata),
        .seq_we(seq_we), .seq_waddr(seq_waddr), .seq_wdata(seq_wdata),
        .ext_start(ext_start), .ext_trig(ext_trig),
        .adc_data(adc_data), .fifo_pop(fifo_pop),
        .mux_sel(mux_sel), .sample_stb(sample_stb), .status(status),
        .fifo_dout(fifo_dout), .fifo_irq(fifo_irq), .blk_done(blk_done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        adc_data <= adc_data + 16'h0111;
    end

    always @(negedge clk) begin
        if (sample_stb && n < 64) begin
            stb_sel[n]  = mux_sel;
            stb_stat[n] = status;
            stb_data[n] = adc_data;
            stb_t[n]    = cyc;
            n = n + 1;
        end
        if (blk_done && nd < 16) begin
            done_at[nd] = n;
            nd = nd + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0; ctl_wdata = '0;
    endtask

    task automatic pulse_trig();
        ext_trig = 1'b1;
        @(negedge clk);
        ext_trig = 1'b0;
    endtask

    task automatic pop_check(input logic [15:0] exp, input string req);
        chk(status[1] == 1'b1, req, "not-empty before pop", int'(status[1]), 1);
        chk(fifo_dout == exp, req, "fifo word", int'(fifo_dout), int'(exp));
        fifo_pop = 1'b1;
        @(negedge clk);
        fifo_pop = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1;
        ctl_we = 0; rate_we = 0; blk_we = 0; seq_we = 0;
        ctl_wdata = '0; rate_wdata = '0; blk_wdata = '0; seq_wdata = '0; seq_waddr = '0;
        ext_start = 0; ext_trig = 0; fifo_pop = 0;
        adc_data = 16'h1234;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R13 reset state
        chk(mux_sel == 8'h00, "R13", "mux_sel", int'(mux_sel), 0);
        chk(status == 16'h0000, "R13", "status", int'(status), 0);
        chk(!sample_stb && !blk_done && !fifo_irq, "R13", "strobes",
            int'({sample_stb, blk_done, fifo_irq}), 0);

        // load rate, block size and program
        rate_we = 1; rate_wdata = RATE; @(negedge clk); rate_we = 0;
        blk_we = 1; blk_wdata = 16'd5; @(negedge clk); blk_we = 0;
        for (int e = 0; e < NENT; e++) begin
            seq_we = 1; seq_waddr = 11'(2*e); seq_wdata = PROG[e].w0; @(negedge clk);
            seq_waddr = 11'(2*e+1); seq_wdata = PROG[e].w1; @(negedge clk);
        end
        seq_waddr = 11'(2*NENT); seq_wdata = 16'h0000; @(negedge clk);
        seq_waddr = 11'(2*NENT+1); @(negedge clk);
        seq_we = 0;

        // R5 internal start, walk the table (R1, R3, R4, R7)
        wr_ctl(8'h10);
        repeat (60) @(negedge clk);
        begin
            int j = 0;
            int last_e = -1;
            for (int e = 0; e < NENT; e++) begin
                if (PROG[e].stb) begin
                    chk(stb_sel[j] == PROG[e].sel, "R1", "mux_sel at strobe",
                        int'(stb_sel[j]), int'(PROG[e].sel));
                    chk(stb_stat[j][13:6] == PROG[e].sel, "R7", "status channel",
                        int'(stb_stat[j][13:6]), int'(PROG[e].sel));
                    if (last_e >= 0)
                        chk(stb_t[j] - stb_t[j-1] == (e - last_e) * STEP, "R3",
                            "strobe spacing", stb_t[j] - stb_t[j-1], (e - last_e) * STEP);
                    last_e = e;
                    j++;
                end
            end
        end
        chk(n == 4, "R4", "strobes in one scan (track silent)", n, 4);

        // R5 trigger start, R8 mid-scan request ignored, R2 restart at entry 0
        wr_ctl(8'h40);
        pulse_trig();
        repeat (10) @(negedge clk);
        pulse_trig();
        repeat (60) @(negedge clk);
        chk(n == 8, "R8", "strobes after two scans", n, 8);
        chk(stb_sel[4] == 8'h5A, "R2", "second scan first channel", int'(stb_sel[4]), 8'h5A);
        chk(nd == 1 && done_at[0] == 5, "R9", "block done across scans", done_at[0], 5);

        // R5 external start edge, R9, R12, R10
        wr_ctl(8'hE0);
        ext_start = 1'b1;
        repeat (60) @(negedge clk);
        chk(n == 12, "R5", "external start scan strobes", n, 12);
        chk(nd == 2 && done_at[1] == 10, "R9", "second block done", done_at[1], 10);
        chk(fifo_irq == 1'b1, "R12", "irq with enable and data", int'(fifo_irq), 1);
        ext_start = 1'b0;
        repeat (3) @(negedge clk);
        chk(nd == 3 && done_at[2] == 12, "R10", "forced done on start fall", nd, 3);

        // R6 FIFO order
        for (int k = 0; k < 6; k++) pop_check(stb_data[k], "R6");

        // R11 soft reset
        wr_ctl(8'h01);
        chk(status[1] == 1'b0, "R11", "FIFO emptied", int'(status[1]), 0);
        chk(fifo_irq == 1'b0, "R12", "irq after soft reset", int'(fifo_irq), 0);
        pulse_trig();
        ext_start = 1'b1;
        repeat (40) @(negedge clk);
        ext_start = 1'b0;
        @(negedge clk);
        chk(n == 12, "R11", "enables cleared, no scan", n, 12);
        fifo_pop = 1'b1; @(negedge clk); fifo_pop = 1'b0;
        chk(status[1] == 1'b0, "R6", "pop on empty", int'(status[1]), 0);

        wr_ctl(8'h10);
        repeat (60) @(negedge clk);
        chk(n == 16 && stb_sel[12] == 8'h5A, "R11", "scan from entry 0 after soft reset",
            int'(stb_sel[12]), 8'h5A);
        chk(fifo_irq == 1'b0, "R12", "irq with enable clear", int'(fifo_irq), 0);
        pop_check(stb_data[12], "R11");
        pop_check(stb_data[13], "R6");

        summary();
        $finish;
    end

endmodule